// File: doc/BRIEF.md
# Reference-Counted Pointer Store Unit

This unit sits in front of a heap of two-field nodes and turns every processor store into a single read-modify-write. Each node owns a left word and a right word. Each word carries its own live/dead tag: live marks a pointer, and dead marks an atomic value or NIL. A store reads the old word and its tag, writes the new word, and retags the field from the type of the destination node. In the same cycle it queues the reference-count messages the store implies. Each message is a node address plus a kind bit, 1 for increment and 0 for decrement.

The messages leave through a ready/valid port that a count processor drains. The processor that issues the stores never waits for the counting to finish. A store into a binary node increments the referent of the new pointer. A store over a live word decrements the referent of the old pointer. When a store needs both, the increment is always queued first, so a pointer written over itself can never see its count fall to zero in between.

A two-state controller paces the store side. `S_OPEN` accepts a store when the message queue has two free slots. The transition `accept` moves it to `S_SETTLE`, which refuses stores for one cycle, and the transition `settle_done` returns it to `S_OPEN`. A side port gives read access to any word and its tag, so software can look at node contents.

Top module: `rcps_store_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, every word of every node reads 0 with a dead tag, `cnt_valid` is low, and `wr_ready` is high.
- R2: An accepted store writes `wr_data` into the word chosen by address bit 2 (0 selects left, 1 selects right) of the node given by the address bits above bit 2. From the next cycle `obs_data` shows the new word, and the other word of that node keeps its value.
- R3: After an accepted store, the tag of the written word is live when `wr_binary` was 1 and dead when it was 0.
- R4: A store with `wr_binary` = 1 queues one message with `cnt_inc` = 1 and `cnt_addr` equal to `wr_data` with bit 2 cleared.
- R5: A store over a live word queues one message with `cnt_inc` = 0 and `cnt_addr` equal to the old word with bit 2 cleared.
- R6: When one store queues both messages, the increment leaves the count port before the decrement, and messages of different stores leave in store order.
- R7: A store with `wr_binary` = 0 over a dead word queues no message.
- R8: A store is accepted at most every second cycle. After an accepted store, `wr_ready` is low for exactly one cycle, then returns high if the queue has room.
- R9: `wr_ready` stays low while the queue has fewer than two free slots. While `cnt_valid` is high and `cnt_ready` is low, `cnt_valid`, `cnt_addr` and `cnt_inc` hold their values.
- R10: Storing into a live word the same pointer it already holds queues an increment and then a decrement of the same node address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Store accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Byte address of the target word; bit 2 selects the field |
| wr_data | input | DATA_W | Word to store |
| wr_binary | input | 1 | Destination node is binary (stored word becomes live) |
| cnt_valid | output | 1 | A count message is available |
| cnt_ready | input | 1 | Count processor takes the message |
| cnt_addr | output | DATA_W | Node address the message refers to |
| cnt_inc | output | 1 | 1 = increment, 0 = decrement |
| obs_addr | input | ADDR_W | Byte address of a word to inspect |
| obs_data | output | DATA_W | Content of the inspected word |
| obs_live | output | 1 | Tag of the inspected word |

## Verification
The bench goes after the ordering corner: a store over a live pointer, and in particular a pointer stored over itself. A design that queued the decrement first would send the count processor a decrement ahead of the matching increment, and could free a node that is still referenced. It checks that the tags follow the node type, so a store of atomic data over a pointer must yield a decrement only and a dead tag; a design that kept the old tag would later decrement a plain number. It fills the queue with the count port stalled and watches that the third store is held off and that no message is lost or reordered. It also checks the accept-then-settle rhythm of the store side, which a design without the settle cycle would break.

// File: rtl/rcps_pkg.sv
package rcps_pkg;

    typedef enum logic [0:0] {
        S_OPEN   = 1'b0,
        S_SETTLE = 1'b1
    } ctrl_state_t;

    typedef enum logic {
        MSG_DEC = 1'b0,
        MSG_INC = 1'b1
    } msg_kind_t;

endpackage

// File: rtl/rcps_ctrl.sv
module rcps_ctrl
    import rcps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic room2,
    output logic wr_ready,
    output logic accept
);

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN:   if (wr_valid && room2) state_d = S_SETTLE; // accept
            S_SETTLE: state_d = S_OPEN;                          // settle_done
            default:  state_d = S_OPEN;
        endcase
    end

    always_comb begin
        wr_ready = 1'b0;
        unique case (state_q)
            S_OPEN:   wr_ready = room2;
            S_SETTLE: wr_ready = 1'b0;
            default:  wr_ready = 1'b0;
        endcase
        accept = wr_ready && wr_valid;
    end

endmodule

// File: rtl/rcps_node_store.sv
module rcps_node_store #(
    parameter int NODE_AW = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NODE_AW-1:0] w_node,
    input  logic               w_right,
    input  logic [DATA_W-1:0]  w_data,
    input  logic               w_live,
    output logic [DATA_W-1:0]  old_data,
    output logic               old_live,
    input  logic [NODE_AW-1:0] r_node,
    input  logic               r_right,
    output logic [DATA_W-1:0]  r_data,
    output logic               r_live
);

    localparam int NODES = 1 << NODE_AW;

    logic [DATA_W-1:0] left_q  [NODES];
    logic [DATA_W-1:0] right_q [NODES];
    logic [NODES-1:0]  llive_q;
    logic [NODES-1:0]  rlive_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NODES; i++) begin
                left_q[i]  <= '0;
                right_q[i] <= '0;
            end
            llive_q <= '0;
            rlive_q <= '0;
        end else if (we) begin
            if (w_right) begin
                right_q[w_node] <= w_data;
                rlive_q[w_node] <= w_live;
            end else begin
                left_q[w_node]  <= w_data;
                llive_q[w_node] <= w_live;
            end
        end
    end

    // Old contents seen in the same cycle the new word is written.
    always_comb begin
        old_data = w_right ? right_q[w_node] : left_q[w_node];
        old_live = w_right ? rlive_q[w_node] : llive_q[w_node];
    end

    always_comb begin
        r_data = r_right ? right_q[r_node] : left_q[r_node];
        r_live = r_right ? rlive_q[r_node] : llive_q[r_node];
    end

endmodule

// File: rtl/rcps_msg_fifo.sv
module rcps_msg_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push0,
    input  logic              push0_inc,
    input  logic [DATA_W-1:0] push0_addr,
    input  logic              push1,
    input  logic              push1_inc,
    input  logic [DATA_W-1:0] push1_addr,
    output logic              room2,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic              pop_inc,
    output logic [DATA_W-1:0] pop_addr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0]  inc_q;
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop;
    logic [1:0]        n_push;
    logic [PTR_W-1:0]  wptr_nx;

    assign pop       = pop_valid && pop_ready;
    assign n_push    = {1'b0, push0} + {1'b0, push1};
    assign wptr_nx   = wptr_q + PTR_W'(1);
    assign pop_valid = (cnt_q != '0);
    assign room2     = (cnt_q <= CNT_W'(DEPTH - 2));
    assign pop_addr  = addr_q[rptr_q];
    assign pop_inc   = inc_q[rptr_q];

    always_ff @(posedge clk) begin
        if (push0) begin
            addr_q[wptr_q] <= push0_addr;
            inc_q[wptr_q]  <= push0_inc;
        end
        if (push1) begin
            addr_q[wptr_nx] <= push1_addr;
            inc_q[wptr_nx]  <= push1_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= wptr_q + PTR_W'(n_push);
            if (pop) rptr_q <= rptr_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(n_push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/rcps_store_unit.sv
module rcps_store_unit
    import rcps_pkg::*;
#(
    parameter int NODE_AW    = 4,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = NODE_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_binary,
    output logic              cnt_valid,
    input  logic              cnt_ready,
    output logic [DATA_W-1:0] cnt_addr,
    output logic              cnt_inc,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic [DATA_W-1:0] obs_data,
    output logic              obs_live
);

    localparam logic [DATA_W-1:0] FIELD_MASK = ~(DATA_W'(4));

    logic              accept;
    logic              room2;
    logic [DATA_W-1:0] old_data;
    logic              old_live;
    logic              gen_inc;
    logic              gen_dec;
    logic              p0;
    logic              p0_inc;
    logic [DATA_W-1:0] p0_addr;
    logic              p1;
    logic [DATA_W-1:0] inc_addr;
    logic [DATA_W-1:0] dec_addr;

    rcps_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .room2    (room2),
        .wr_ready (wr_ready),
        .accept   (accept)
    );

    rcps_node_store #(
        .NODE_AW (NODE_AW),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (accept),
        .w_node   (wr_addr[ADDR_W-1:3]),
        .w_right  (wr_addr[2]),
        .w_data   (wr_data),
        .w_live   (wr_binary),
        .old_data (old_data),
        .old_live (old_live),
        .r_node   (obs_addr[ADDR_W-1:3]),
        .r_right  (obs_addr[2]),
        .r_data   (obs_data),
        .r_live   (obs_live)
    );

    // Increment for the new referent always takes the first slot.
    assign gen_inc  = accept && wr_binary;
    assign gen_dec  = accept && old_live;
    assign inc_addr = wr_data & FIELD_MASK;
    assign dec_addr = old_data & FIELD_MASK;
    assign p0       = gen_inc || gen_dec;
    assign p0_inc   = gen_inc;
    assign p0_addr  = gen_inc ? inc_addr : dec_addr;
    assign p1       = gen_inc && gen_dec;

    rcps_msg_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .DATA_W (DATA_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push0      (p0),
        .push0_inc  (p0_inc),
        .push0_addr (p0_addr),
        .push1      (p1),
        .push1_inc  (MSG_DEC),
        .push1_addr (dec_addr),
        .room2      (room2),
        .pop_valid  (cnt_valid),
        .pop_ready  (cnt_ready),
        .pop_inc    (cnt_inc),
        .pop_addr   (cnt_addr)
    );

endmodule

// File: rtl/rcps_checker.sv
module rcps_checker #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_binary,
    input logic              cnt_valid,
    input logic              cnt_ready,
    input logic [DATA_W-1:0] cnt_addr,
    input logic              cnt_inc,
    input logic [ADDR_W-1:0] obs_addr,
    input logic [DATA_W-1:0] obs_data,
    input logic              obs_live
);

    localparam logic [DATA_W-1:0] FMASK = ~(DATA_W'(4));

    logic acc;
    logic same_word;
    assign acc       = wr_valid && wr_ready;
    assign same_word = (obs_addr[ADDR_W-1:2] == wr_addr[ADDR_W-1:2]);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (!cnt_valid);
        end
    end

    assert_write_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && same_word) |=>
        (!$stable(obs_addr) || (obs_data == $past(wr_data) && obs_live == $past(wr_binary))));

    assert_inc_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_binary && !cnt_valid) |=>
        (cnt_valid && cnt_inc && cnt_addr == ($past(wr_data) & FMASK)));

    assert_dead_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr_binary && !cnt_valid && same_word && !obs_live) |=> !cnt_valid);

    assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !wr_ready);

    assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !cnt_ready) |=> (cnt_valid && $stable(cnt_addr) && $stable(cnt_inc)));

endmodule

bind rcps_store_unit rcps_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_binary (wr_binary),
    .cnt_valid (cnt_valid),
    .cnt_ready (cnt_ready),
    .cnt_addr  (cnt_addr),
    .cnt_inc   (cnt_inc),
    .obs_addr  (obs_addr),
    .obs_data  (obs_data),
    .obs_live  (obs_live)
);

// File: tb/rcps_store_unit_bench.sv
module rcps_store_unit_bench;

    localparam int NODE_AW = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = NODE_AW + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_binary = 1'b0;
    logic              cnt_valid;
    logic              cnt_ready = 1'b1;
    logic [DATA_W-1:0] cnt_addr;
    logic              cnt_inc;
    logic [ADDR_W-1:0] obs_addr = '0;
    logic [DATA_W-1:0] obs_data;
    logic              obs_live;

    int checks = 0;
    int errors = 0;
    int log_n  = 0;
    logic [DATA_W-1:0] log_addr [64];
    logic              log_inc  [64];

    always #5 clk = ~clk;

    rcps_store_unit #(
        .NODE_AW    (NODE_AW),
        .DATA_W     (DATA_W),
        .FIFO_DEPTH (4)
    ) u_rcps_store_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_binary (wr_binary),
        .cnt_valid (cnt_valid),
        .cnt_ready (cnt_ready),
        .cnt_addr  (cnt_addr),
        .cnt_inc   (cnt_inc),
        .obs_addr  (obs_addr),
        .obs_data  (obs_data),
        .obs_live  (obs_live)
    );

    // A transfer seen at the falling edge completes at the next rising edge;
    // cnt_ready only changes just after a rising edge.
    always @(negedge clk) begin
        if (rst_n && cnt_valid && cnt_ready && log_n < 64) begin
            log_addr[log_n] = cnt_addr;
            log_inc[log_n]  = cnt_inc;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic b);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_binary = b; obs_addr = a;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_msg(input int idx, input logic inc, input logic [31:0] addr,
                              input string req);
        check(log_n > idx, req, "message present", 32'(log_n), 32'(idx + 1));
        if (log_n > idx) begin
            check(log_inc[idx] == inc, req, "message kind", 32'(log_inc[idx]), 32'(inc));
            check(log_addr[idx] == addr, req, "message address", log_addr[idx], addr);
        end
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a);
        obs_addr = a;
        #1;
    endtask

    task automatic t_reset();
        int bad = 0;
        for (int n = 0; n < (1 << NODE_AW); n++) begin
            for (int f = 0; f < 2; f++) begin
                peek(ADDR_W'((n << 3) | (f << 2)));
                if (obs_data != '0 || obs_live) bad++;
            end
        end
        check(bad == 0, "R1", "words nonzero or live after reset", 32'(bad), 0);
        check(!cnt_valid, "R1", "cnt_valid after reset", 32'(cnt_valid), 0);
        check(wr_ready, "R1", "wr_ready after reset", 32'(wr_ready), 1);
    endtask

    task automatic t_atomic_dead();
        log_n = 0;
        do_write(7'h08, 32'h1234, 1'b0);
        drain();
        peek(7'h08);
        check(obs_data == 32'h1234, "R2", "left word of node 1", obs_data, 32'h1234);
        check(!obs_live, "R3", "atomic word tag", 32'(obs_live), 0);
        peek(7'h0C);
        check(obs_data == 0, "R2", "right word of node 1 untouched", obs_data, 0);
        check(log_n == 0, "R7", "messages for dead-over-dead", 32'(log_n), 0);
    endtask

    task automatic t_pointer_new();
        log_n = 0;
        do_write(7'h14, 32'h4C, 1'b1);
        drain();
        peek(7'h14);
        check(obs_data == 32'h4C, "R2", "right word of node 2", obs_data, 32'h4C);
        check(obs_live, "R3", "pointer word tag", 32'(obs_live), 1);
        peek(7'h10);
        check(obs_data == 0 && !obs_live, "R2", "left word of node 2 untouched", obs_data, 0);
        check(log_n == 1, "R4", "message count", 32'(log_n), 1);
        expect_msg(0, 1'b1, 32'h48, "R4");
    endtask

    task automatic t_overwrite_live();
        log_n = 0;
        do_write(7'h14, 32'h20, 1'b1);
        drain();
        check(log_n == 2, "R6", "message count", 32'(log_n), 2);
        expect_msg(0, 1'b1, 32'h20, "R6");
        expect_msg(1, 1'b0, 32'h48, "R5");
        log_n = 0;
        do_write(7'h14, 32'h99, 1'b0);
        drain();
        peek(7'h14);
        check(!obs_live, "R3", "tag after atomic over pointer", 32'(obs_live), 0);
        check(log_n == 1, "R5", "message count atomic over pointer", 32'(log_n), 1);
        expect_msg(0, 1'b0, 32'h20, "R5");
    endtask

    task automatic t_self_assign();
        do_write(7'h10, 32'h30, 1'b1);
        drain();
        log_n = 0;
        do_write(7'h10, 32'h30, 1'b1);
        drain();
        check(log_n == 2, "R10", "message count self-store", 32'(log_n), 2);
        expect_msg(0, 1'b1, 32'h30, "R10");
        expect_msg(1, 1'b0, 32'h30, "R10");
    endtask

    task automatic t_rate();
        int accepted = 0;
        logic [5:0] seen = '0;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 7'h20; wr_data = 32'h77; wr_binary = 1'b0; obs_addr = 7'h20;
        for (int i = 0; i < 6; i++) begin
            seen[i] = wr_ready;
            if (wr_ready) accepted++;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        check(seen == 6'b010101, "R8", "wr_ready pattern under back-to-back stores",
              32'(seen), 32'h15);
        check(accepted == 3, "R8", "stores accepted in six cycles", 32'(accepted), 3);
    endtask

    task automatic t_stall();
        int low = 0;
        int moved = 0;
        log_n = 0;
        @(posedge clk); #1 cnt_ready = 1'b0;
        do_write(7'h18, 32'h40, 1'b1);
        do_write(7'h18, 32'h50, 1'b1);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 7'h18; wr_data = 32'h60; wr_binary = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (!wr_ready) low++;
            if (!(cnt_valid && cnt_inc && cnt_addr == 32'h40)) moved++;
            @(negedge clk);
        end
        check(low == 4, "R9", "cycles wr_ready low with one free slot", 32'(low), 4);
        check(moved == 0, "R9", "head message changed while stalled", 32'(moved), 0);
        @(posedge clk); #1 cnt_ready = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        drain();
        check(log_n == 5, "R9", "messages after release", 32'(log_n), 5);
        expect_msg(0, 1'b1, 32'h40, "R6");
        expect_msg(1, 1'b1, 32'h50, "R6");
        expect_msg(2, 1'b0, 32'h40, "R6");
        expect_msg(3, 1'b1, 32'h60, "R6");
        expect_msg(4, 1'b0, 32'h50, "R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_atomic_dead();
        t_pointer_new();
        t_overwrite_live();
        t_self_assign();
        t_rate();
        drain();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule